// File: doc/BRIEF.md
# Supply Supervisor Reset and Monitor Logic

This block is the digital back end of a supply supervisor. Analog comparators outside the block report three conditions. The first is whether the main supply sits above its trip level. The other two are whether each of two auxiliary rails sits above its own trip level. A fourth input is a manual reset pin. Every one of these inputs is asynchronous to the block clock, so each passes through a two-flop synchronizer before any logic uses it.

The main reset output is active high. It asserts whenever the main supply is low or the manual reset pin is held high. Once both of those causes have cleared, the output stays high for a stretch and then drops. Software sets the length of that stretch through a 2-bit selector. The stretch is counted in units of a prescaled tick. If a new cause appears while the stretch is running, the count starts again from zero.

The two auxiliary outputs follow their synchronized comparators directly, with no stretch. A capture strobe copies their current levels into two status bits, which the serial port logic can then read.

Top module: `supsv_top`

## Requirements
- R1: While the main-supply comparator input is low, the main reset output is high. A fall of the comparator input shows on the output after the third rising clock edge that follows the fall.
- R2: After the last reset cause clears, the main reset output stays high for exactly LIMIT×PRESCALE clock cycles. Measured from a change of the raw input, the output goes low at the (LIMIT×PRESCALE+2)-th rising edge.
- R3: The selector `to_sel_i` chooses LIMIT as follows: code 0 gives TO_0 (50), code 1 gives TO_1 (100), code 2 gives TO_2 (200) and code 3 gives TO_3 (400) units. One unit is PRESCALE clock cycles, with a default of 4.
- R4: A high level on the manual reset input forces the main reset output high, with the same three-edge latency as R1. After the manual input returns low, the output stays high for the same stretch as in R2.
- R5: Each auxiliary output equals its raw comparator input as it was two rising edges earlier. No stretch is applied, whatever the state of the main reset.
- R6: When `stat_cap_i` is high at a rising edge, `stat_o` takes the auxiliary outputs as they were before that edge. Bit 0 holds auxiliary A and bit 1 holds auxiliary B. At every other edge, `stat_o` holds its value.
- R7: A new reset cause that arrives while the stretch is counting restarts the stretch. The output then falls LIMIT×PRESCALE cycles after the new cause clears.
- R8: While `rst_n` is low, the main reset output is 1 and the auxiliary outputs and `stat_o` are 0. After release with the supply good, the main reset output falls at rising edge LIMIT×PRESCALE+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| supply_ok_i | input | 1 | Main supply comparator, 1 = above trip level |
| aux_a_i | input | 1 | Auxiliary monitor A comparator, 1 = above trip level |
| aux_b_i | input | 1 | Auxiliary monitor B comparator, 1 = above trip level |
| man_rst_i | input | 1 | Manual reset request, active high |
| to_sel_i | input | 2 | Stretch length selector (see R3) |
| stat_cap_i | input | 1 | Capture strobe for the status bits |
| sup_rst_o | output | 1 | Main reset output, active high |
| aux_a_o | output | 1 | Auxiliary monitor A output |
| aux_b_o | output | 1 | Auxiliary monitor B output |
| stat_o | output | 2 | Captured auxiliary levels: bit 1 is B, bit 0 is A |

## Verification
Two pairs of functions can land on the same edge, and the bench provokes both.

The first pair is the manual reset and the supply recovery. The bench raises the manual input on the same edge that the supply comparator returns high. It then expects the stretch to be measured from the later manual release, with no fall in the gap between the two events.

The second pair is the status capture and an auxiliary output change. The bench holds the capture strobe across exactly the edge on which an auxiliary output changes. It expects the status bit to keep the old level, and to pick up the new level only at the following capture.

// File: rtl/supsv_pkg.sv
`timescale 1ns/1ps
package supsv_pkg;

  localparam int SEL_W = 2;

  // Map the 2-bit stretch selector onto one of four unit counts.
  function automatic int unsigned pick_units(input logic [SEL_W-1:0] sel,
                                             input int unsigned u0,
                                             input int unsigned u1,
                                             input int unsigned u2,
                                             input int unsigned u3);
    case (sel)
      2'd0:    return u0;
      2'd1:    return u1;
      2'd2:    return u2;
      default: return u3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/supsv_sync.sv
`timescale 1ns/1ps
// Multi-bit synchronizer, each bit an independent flop chain.
module supsv_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/supsv_tick.sv
`timescale 1ns/1ps
// Prescaler producing a one-cycle tick every PRESCALE clocks; held at phase zero by hold.
module supsv_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);

  localparam int          PW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    tick = 1'b0;
    if (hold) begin
      pc_d = '0;
    end else if (pc_q == LAST) begin
      pc_d = '0;
      tick = 1'b1;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/supsv_stretch.sv
`timescale 1ns/1ps
// Holds the reset active while cause is present and for LIMIT ticks after it clears.
module supsv_stretch
  import supsv_pkg::*;
#(
  parameter int unsigned TO_0 = 50,
  parameter int unsigned TO_1 = 100,
  parameter int unsigned TO_2 = 200,
  parameter int unsigned TO_3 = 400,
  parameter int          CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cause,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             rst_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1 = CNT_W'(pick_units(sel, TO_0, TO_1, TO_2, TO_3) - 1);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (cause) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q && tick) begin
      if (cnt_q >= lim_m1) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign rst_o = act_q;

endmodule

// File: rtl/supsv_top.sv
`timescale 1ns/1ps
module supsv_top
  import supsv_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          PRESCALE    = 4,
  parameter int unsigned TO_0        = 50,
  parameter int unsigned TO_1        = 100,
  parameter int unsigned TO_2        = 200,
  parameter int unsigned TO_3        = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             aux_a_i,
  input  logic             aux_b_i,
  input  logic             man_rst_i,
  input  logic [SEL_W-1:0] to_sel_i,
  input  logic             stat_cap_i,
  output logic             sup_rst_o,
  output logic             aux_a_o,
  output logic             aux_b_o,
  output logic [1:0]       stat_o
);

  localparam int unsigned TO_MAX = max4(TO_0, TO_1, TO_2, TO_3);
  localparam int          CNT_W  = $clog2(TO_MAX + 1);
  localparam int          IN_W   = 4;
  localparam int          B_OK   = 0;
  localparam int          B_AUXA = 1;
  localparam int          B_AUXB = 2;
  localparam int          B_MAN  = 3;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // Input synchronization.
  logic [IN_W-1:0] raw_in, syn_in;
  assign raw_in[B_OK]   = supply_ok_i;
  assign raw_in[B_AUXA] = aux_a_i;
  assign raw_in[B_AUXB] = aux_b_i;
  assign raw_in[B_MAN]  = man_rst_i;

  supsv_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (raw_in),
    .q    (syn_in)
  );

  logic cause;
  assign cause = ~syn_in[B_OK] | syn_in[B_MAN];

  // Stretch timing.
  logic tick;

  supsv_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk  (clk),
    .rst_n(rst_int_n),
    .hold (cause),
    .tick (tick)
  );

  supsv_stretch #(
    .TO_0 (TO_0),
    .TO_1 (TO_1),
    .TO_2 (TO_2),
    .TO_3 (TO_3),
    .CNT_W(CNT_W)
  ) u_str (
    .clk  (clk),
    .rst_n(rst_int_n),
    .cause(cause),
    .tick (tick),
    .sel  (to_sel_i),
    .rst_o(sup_rst_o)
  );

  // Auxiliary outputs and captured status.
  assign aux_a_o = syn_in[B_AUXA];
  assign aux_b_o = syn_in[B_AUXB];

  logic [1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (stat_cap_i) stat_d = {syn_in[B_AUXB], syn_in[B_AUXA]};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) stat_q <= 2'b00;
    else            stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/supsv_chk.sv
`timescale 1ns/1ps
module supsv_chk
  import supsv_pkg::*;
#(
  parameter int          PRESCALE = 4,
  parameter int unsigned TO_0     = 50,
  parameter int unsigned TO_1     = 100,
  parameter int unsigned TO_2     = 200,
  parameter int unsigned TO_3     = 400
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cause,
  input logic             sup_rst,
  input logic [SEL_W-1:0] to_sel,
  input logic [1:0]       aux_i,
  input logic [1:0]       aux_o,
  input logic             stat_cap,
  input logic [1:0]       stat
);

  // Cycles elapsed since the reset cause was last present.
  int unsigned run_q;
  logic [1:0]  arm_q;
  logic        armed;
  int unsigned lim_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
      arm_q <= 2'd0;
    end else begin
      if (cause)                  run_q <= 0;
      else if (run_q != 32'hFFFF_FFFF) run_q <= run_q + 1;
      if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
    end
  end

  assign armed   = (arm_q == 2'd3);
  assign lim_cyc = pick_units(to_sel, TO_0, TO_1, TO_2, TO_3) * PRESCALE;

  // R1 and R4: a present cause drives the output high on the next edge.
  assert_cause_forces_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> sup_rst);

  // R4: the output only rises because of a cause.
  assert_rise_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_rst) |-> $past(cause));

  // R2, R3 and R7: the fall comes exactly one selected stretch after the last cause.
  assert_stretch_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sup_rst) |-> (run_q == lim_cyc));

  assert_aux_a_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (aux_o[0] == $past(aux_i[0], 2)));

  assert_aux_b_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (aux_o[1] == $past(aux_i[1], 2)));

  assert_stat_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(stat_cap)) |-> (stat == $past(aux_o)));

  assert_stat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(stat_cap)) |-> $stable(stat));

endmodule

bind supsv_top supsv_chk #(
  .PRESCALE(PRESCALE),
  .TO_0    (TO_0),
  .TO_1    (TO_1),
  .TO_2    (TO_2),
  .TO_3    (TO_3)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .cause   (cause),
  .sup_rst (sup_rst_o),
  .to_sel  (to_sel_i),
  .aux_i   ({aux_b_i, aux_a_i}),
  .aux_o   ({aux_b_o, aux_a_o}),
  .stat_cap(stat_cap_i),
  .stat    (stat_o)
);

// File: tb/sim_supsv_top.sv
`timescale 1ns/1ps
module sim_supsv_top;

  localparam int PRESC = 4;
  localparam int UNITS [4] = '{50, 100, 200, 400};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok, aux_a, aux_b, man_rst, stat_cap;
  logic [1:0] to_sel;
  logic       sup_rst, aux_a_o, aux_b_o;
  logic [1:0] stat_o;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  // Scoreboard: expected edge counts from release to fall of the main reset.
  int exp_q [$];
  int since_rel = 0;
  bit mon_on = 0;
  logic prev_rst = 1'b1;

  always #2.5 clk = ~clk;

  supsv_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok_i(supply_ok),
    .aux_a_i    (aux_a),
    .aux_b_i    (aux_b),
    .man_rst_i  (man_rst),
    .to_sel_i   (to_sel),
    .stat_cap_i (stat_cap),
    .sup_rst_o  (sup_rst),
    .aux_a_o    (aux_a_o),
    .aux_b_o    (aux_b_o),
    .stat_o     (stat_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver side: release a cause on a falling edge and queue the expected length.
  task automatic mark_release(input int exp_edges);
    since_rel = 0;
    exp_q.push_back(exp_edges);
  endtask

  task automatic drain(input string req);
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  always @(posedge clk) since_rel <= since_rel + 1;

  // Monitor: on each fall of the main reset, compare against the queue.
  always @(negedge clk) begin
    if (mon_on && prev_rst && !sup_rst) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected fall", since_rel, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(since_rel == e, "R2/R3/R7 stretch length", since_rel, e);
      end
    end
    prev_rst <= sup_rst;
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1; aux_a = 1'b1; aux_b = 1'b1;
    man_rst = 1'b0; stat_cap = 1'b0; to_sel = 2'd0;
    negs(3);
    // R8: reset state.
    check(sup_rst == 1'b1, "R8 reset sup_rst", sup_rst, 1);
    check(aux_a_o == 1'b0 && aux_b_o == 1'b0, "R8 reset aux", {aux_b_o, aux_a_o}, 0);
    check(stat_o == 2'b00, "R8 reset stat", stat_o, 0);
    aux_a = 1'b0; aux_b = 1'b0;
    prev_rst = 1'b1;
    mon_on = 1'b1;
    rst_n = 1'b1;
    mark_release(UNITS[0] * PRESC + 4);   // R8 power-up stretch
    drain("R8 power-up fall");

    // R1: supply drop seen after the third edge.
    @(negedge clk);
    supply_ok = 1'b0;
    negs(2);
    check(sup_rst == 1'b0, "R1 latency early", sup_rst, 0);
    negs(1);
    check(sup_rst == 1'b1, "R1 latency", sup_rst, 1);

    // R2/R3: each selector code.
    for (int s = 0; s < 4; s++) begin
      to_sel = 2'(s);
      negs(2);
      supply_ok = 1'b1;
      mark_release(UNITS[s] * PRESC + 2);
      drain("R3 selector code");
      @(negedge clk);
      supply_ok = 1'b0;
      negs(4);
      check(sup_rst == 1'b1, "R1 held low supply", sup_rst, 1);
    end
    supply_ok = 1'b1;
    to_sel = 2'd1;
    mark_release(UNITS[1] * PRESC + 2);
    drain("R2 settle");

    // R4: manual reset.
    @(negedge clk);
    man_rst = 1'b1;
    negs(2);
    check(sup_rst == 1'b0, "R4 latency early", sup_rst, 0);
    negs(1);
    check(sup_rst == 1'b1, "R4 forced high", sup_rst, 1);
    negs(3);
    man_rst = 1'b0;
    mark_release(UNITS[1] * PRESC + 2);
    drain("R4 manual stretch");

    // R7: restart while counting.
    to_sel = 2'd0;
    @(negedge clk);
    man_rst = 1'b1;
    negs(4);
    man_rst = 1'b0;
    negs(100);
    check(sup_rst == 1'b1, "R7 mid-count", sup_rst, 1);
    man_rst = 1'b1;
    negs(2);
    man_rst = 1'b0;
    mark_release(UNITS[0] * PRESC + 2);
    drain("R7 restart");

    // R7: supply dip during count, then supply recovery and manual reset on one edge.
    @(negedge clk);
    supply_ok = 1'b0;
    negs(4);
    supply_ok = 1'b1;
    negs(60);
    supply_ok = 1'b0;
    negs(3);
    supply_ok = 1'b1;
    man_rst = 1'b1;
    negs(5);
    check(sup_rst == 1'b1, "R4 overlap held", sup_rst, 1);
    man_rst = 1'b0;
    mark_release(UNITS[0] * PRESC + 2);
    drain("R7 overlap");

    // R5: auxiliary outputs, including while the main reset is active.
    @(negedge clk);
    aux_a = 1'b1;
    negs(1);
    check(aux_a_o == 1'b0, "R5 aux A early", aux_a_o, 0);
    negs(1);
    check(aux_a_o == 1'b1, "R5 aux A rise", aux_a_o, 1);
    supply_ok = 1'b0;
    aux_b = 1'b1;
    negs(2);
    check(aux_b_o == 1'b1, "R5 aux B during reset", aux_b_o, 1);
    aux_a = 1'b0;
    negs(2);
    check(aux_a_o == 1'b0, "R5 aux A fall", aux_a_o, 0);
    check(sup_rst == 1'b1, "R1 still high", sup_rst, 1);
    supply_ok = 1'b1;
    mark_release(UNITS[0] * PRESC + 2);
    drain("R5 stretch unaffected");

    // R6: capture, hold, and capture on the edge an aux output changes.
    @(negedge clk);
    stat_cap = 1'b1;
    @(negedge clk);
    stat_cap = 1'b0;
    check(stat_o == 2'b10, "R6 capture", stat_o, 2);
    aux_b = 1'b0; aux_a = 1'b1;
    negs(4);
    check(stat_o == 2'b10, "R6 hold", stat_o, 2);
    aux_a = 1'b0;
    negs(3);
    aux_a = 1'b1;         // aux_a_o changes at the second edge from here
    @(negedge clk);
    stat_cap = 1'b1;      // high across that second edge
    @(negedge clk);
    stat_cap = 1'b0;
    check(aux_a_o == 1'b1, "R5 aux A same edge", aux_a_o, 1);
    check(stat_o == 2'b00, "R6 same-edge old value", stat_o, 0);
    stat_cap = 1'b1;
    @(negedge clk);
    stat_cap = 1'b0;
    check(stat_o == 2'b01, "R6 next capture", stat_o, 1);

    negs(5);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule